// File: doc/BRIEF.md
# Two-Level Linear-to-Physical Page Translator

This block turns a 32-bit linear address into a 32-bit physical address. It uses a small two-level structure held inside the block: a 32-entry directory of 13-bit entries and a 1024-entry page table of 32-bit entries. Both tables are loaded through their own write ports. The linear address is read as three fields. DIR occupies bits [31:22], PAGE bits [21:12] and OFFSET bits [11:0]. Only DIR bits [26:22] select a directory entry, because the directory base is fixed at zero.

Both lookups add rather than concatenate. The selected directory entry plus PAGE gives the page-table slot. The page-table entry plus OFFSET gives the physical address. The requester can also take two shorter paths. It can report a page hit and supply the frame to use, or it can turn paging off so that the address passes through unchanged. Every accepted request produces exactly one result, marked by a valid flag two clock edges later. Results come out in request order, one per cycle.

Top module: `pgx_translator`

## Requirements
- R1: With paging enabled and no hit, the directory entry is selected by linear-address bits [26:22] only; bits [31:27] have no effect on the walk result.
- R2: The page-table slot is the selected 13-bit directory entry plus the PAGE field (bits [21:12]), keeping only the low 10 bits of the sum.
- R3: On a walk the physical address is the selected 32-bit page-table entry plus the zero-extended 12-bit OFFSET (bits [11:0]), modulo 2^32.
- R4: With paging_en low, the physical address equals the linear address.
- R5: With paging_en high and hit high, the physical address equals hit_frame, whatever the table contents.
- R6: A request presented with req_valid at a rising edge yields phys_valid high after the second rising edge that follows it. Back-to-back requests yield results on consecutive cycles in request order.
- R7: In a cycle with no result due, phys_valid is low and phys_addr holds its previous value.
- R8: Synchronous reset drives phys_valid low and phys_addr to zero and clears both tables to zero, so a walk after reset returns just the OFFSET.
- R9: A directory write at the same edge as a request does not change that request's result; requests presented at later edges use the new entry.
- R10: With paging_en low, hit and hit_frame have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A translation request is presented this cycle |
| lin_addr | input | 32 | Linear address to translate |
| paging_en | input | 1 | Enables translation; when low the address passes through |
| hit | input | 1 | The requester already holds the frame for this address |
| hit_frame | input | 32 | Physical address to use on a hit |
| dir_we | input | 1 | Directory write strobe |
| dir_waddr | input | 5 | Directory entry to write |
| dir_wdata | input | 13 | Directory entry value |
| pt_we | input | 1 | Page-table write strobe |
| pt_waddr | input | 10 | Page-table entry to write |
| pt_wdata | input | 32 | Page-table entry value |
| phys_addr | output | 32 | Translated physical address |
| phys_valid | output | 1 | phys_addr carries a new result this cycle |

## Verification
Walks are run with table values chosen so that each arithmetic step can be seen. A directory entry near the top of its range shows that the slot sum wraps. A page-table entry near 2^32 shows that the offset carry is dropped. Two linear addresses that differ only in DIR bits [31:27] must give the same result. Hit and pass-through requests use addresses whose walk result would differ, so a wrong path choice shows up in the output. A mixed back-to-back stream followed by idle cycles checks ordering, valid timing and hold. A directory rewrite issued at the same edge as a request checks which entry that request uses.

// File: rtl/pgx_pkg.sv
package pgx_pkg;

    // address geometry
    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned DIR_W     = 10;
    localparam int unsigned PAGE_W    = 10;
    localparam int unsigned OFF_W     = 12;

    // table geometry
    localparam int unsigned DIR_DEPTH = 32;
    localparam int unsigned DIR_ENT_W = 13;
    localparam int unsigned PT_DEPTH  = 1024;
    localparam int unsigned PT_ENT_W  = 32;

    localparam int unsigned DIR_IDX_W = $clog2(DIR_DEPTH);
    localparam int unsigned PT_IDX_W  = $clog2(PT_DEPTH);

    typedef logic [ADDR_W-1:0] addr_t;

    // linear address seen as its three fields, most significant first
    typedef struct packed {
        logic [DIR_W-1:0]  dir;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } lin_t;

    // which way a request leaves the pipeline
    typedef enum logic [1:0] {
        PATH_IDLE  = 2'd0,
        PATH_PASS  = 2'd1,
        PATH_FRAME = 2'd2,
        PATH_WALK  = 2'd3
    } path_e;

    // contents of the first pipeline register
    typedef struct packed {
        path_e             path;
        addr_t             pass_val;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
    } stage_t;

    function automatic lin_t split_lin(input addr_t a);
        return lin_t'(a);
    endfunction

    // paging disabled wins over a hit, a hit wins over a walk
    function automatic path_e choose_path(input logic req, input logic en, input logic hit_in);
        path_e p;
        if (!req)         p = PATH_IDLE;
        else if (!en)     p = PATH_PASS;
        else if (hit_in)  p = PATH_FRAME;
        else              p = PATH_WALK;
        return p;
    endfunction

    // additive slot selection, wrapped to the table size
    function automatic logic [PT_IDX_W-1:0] table_slot(input logic [DIR_ENT_W-1:0] ent,
                                                      input logic [PAGE_W-1:0]    page);
        return PT_IDX_W'(ent + DIR_ENT_W'(page));
    endfunction

    // frame entry plus byte offset, carry out of the top dropped
    function automatic addr_t add_offset(input logic [PT_ENT_W-1:0] ent,
                                         input logic [OFF_W-1:0]    off);
        return addr_t'(ent) + addr_t'(off);
    endfunction

endpackage

// File: rtl/pgx_store.sv
module pgx_store
    import pgx_pkg::*;
#(
    parameter int unsigned DEPTH     = 32,
    parameter int unsigned WIDTH     = 13,
    parameter bit          SYNC_READ = 1'b1,
    localparam int unsigned IDX_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] ent [DEPTH];

    // single write port; every entry cleared by reset
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent[i] <= '0;
            end
        end else if (we) begin
            ent[waddr] <= wdata;
        end
    end

    // read style picked per instance
    if (SYNC_READ) begin : g_sync
        logic [WIDTH-1:0] rd_q;
        always_ff @(posedge clk) begin
            if (rst) rd_q <= '0;
            else     rd_q <= ent[raddr];
        end
        assign rdata = rd_q;
    end else begin : g_async
        assign rdata = ent[raddr];
    end

endmodule

// File: rtl/pgx_issue.sv
module pgx_issue
    import pgx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  addr_t                lin_addr,
    input  logic                 paging_en,
    input  logic                 hit,
    input  addr_t                hit_frame,
    output logic [DIR_IDX_W-1:0] dir_raddr,
    output stage_t               stage_q
);

    lin_t   fields;
    stage_t stage_d;

    always_comb begin
        fields    = split_lin(lin_addr);
        // base fixed at zero: low DIR bits index the directory directly
        dir_raddr = fields.dir[DIR_IDX_W-1:0];

        stage_d.path     = choose_path(req_valid, paging_en, hit);
        stage_d.pass_val = (stage_d.path == PATH_FRAME) ? hit_frame : lin_addr;
        stage_d.page     = fields.page;
        stage_d.off      = fields.off;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q.path     <= PATH_IDLE;
            stage_q.pass_val <= '0;
            stage_q.page     <= '0;
            stage_q.off      <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

endmodule

// File: rtl/pgx_finish.sv
module pgx_finish
    import pgx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  stage_t               stage_q,
    input  logic [DIR_ENT_W-1:0] dir_ent,
    input  logic [PT_ENT_W-1:0]  pt_ent,
    output logic [PT_IDX_W-1:0]  pt_raddr,
    output addr_t                phys_addr,
    output logic                 phys_valid
);

    always_comb begin
        pt_raddr = table_slot(dir_ent, stage_q.page);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phys_valid <= 1'b0;
            phys_addr  <= '0;
        end else begin
            phys_valid <= (stage_q.path != PATH_IDLE);
            unique case (stage_q.path)
                PATH_PASS,
                PATH_FRAME: phys_addr <= stage_q.pass_val;
                PATH_WALK:  phys_addr <= add_offset(pt_ent, stage_q.off);
                default:    phys_addr <= phys_addr;
            endcase
        end
    end

endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
    import pgx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    lin_addr,
    input  logic                 paging_en,
    input  logic                 hit,
    input  logic [ADDR_W-1:0]    hit_frame,
    input  logic                 dir_we,
    input  logic [DIR_IDX_W-1:0] dir_waddr,
    input  logic [DIR_ENT_W-1:0] dir_wdata,
    input  logic                 pt_we,
    input  logic [PT_IDX_W-1:0]  pt_waddr,
    input  logic [PT_ENT_W-1:0]  pt_wdata,
    output logic [ADDR_W-1:0]    phys_addr,
    output logic                 phys_valid
);

    logic [DIR_IDX_W-1:0] dir_raddr;
    logic [DIR_ENT_W-1:0] dir_ent;
    logic [PT_IDX_W-1:0]  pt_raddr;
    logic [PT_ENT_W-1:0]  pt_ent;
    stage_t               stage_q;

    // cycle 1: capture request, read directory
    pgx_issue u_issue (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .lin_addr  (lin_addr),
        .paging_en (paging_en),
        .hit       (hit),
        .hit_frame (hit_frame),
        .dir_raddr (dir_raddr),
        .stage_q   (stage_q)
    );

    pgx_store #(
        .DEPTH     (DIR_DEPTH),
        .WIDTH     (DIR_ENT_W),
        .SYNC_READ (1'b1)
    ) u_dir (
        .clk   (clk),
        .rst   (rst),
        .we    (dir_we),
        .waddr (dir_waddr),
        .wdata (dir_wdata),
        .raddr (dir_raddr),
        .rdata (dir_ent)
    );

    // cycle 2: page-table read, offset add, output register
    pgx_store #(
        .DEPTH     (PT_DEPTH),
        .WIDTH     (PT_ENT_W),
        .SYNC_READ (1'b0)
    ) u_pt (
        .clk   (clk),
        .rst   (rst),
        .we    (pt_we),
        .waddr (pt_waddr),
        .wdata (pt_wdata),
        .raddr (pt_raddr),
        .rdata (pt_ent)
    );

    pgx_finish u_finish (
        .clk        (clk),
        .rst        (rst),
        .stage_q    (stage_q),
        .dir_ent    (dir_ent),
        .pt_ent     (pt_ent),
        .pt_raddr   (pt_raddr),
        .phys_addr  (phys_addr),
        .phys_valid (phys_valid)
    );

endmodule

// File: rtl/pgx_translator_chk.sv
module pgx_translator_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] lin_addr,
    input logic        paging_en,
    input logic        hit,
    input logic [31:0] hit_frame,
    input logic [31:0] phys_addr,
    input logic        phys_valid
);

    a_r6_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ##2 phys_valid);

    a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> ##2 !phys_valid);

    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !phys_valid |-> $stable(phys_addr));

    a_r4_passthrough: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !paging_en) |-> ##2 (phys_addr == $past(lin_addr, 2)));

    a_r5_hit_frame: assert property (@(posedge clk) disable iff (rst)
        (req_valid && paging_en && hit) |-> ##2 (phys_addr == $past(hit_frame, 2)));

    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!phys_valid && phys_addr == 32'd0));

endmodule

bind pgx_translator pgx_translator_chk u_chk (.*);

// File: tb/sim_pgx_translator.sv
`timescale 1ns/1ps
module sim_pgx_translator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] lin_addr = '0;
    logic        paging_en = 1'b0;
    logic        hit = 1'b0;
    logic [31:0] hit_frame = '0;
    logic        dir_we = 1'b0;
    logic [4:0]  dir_waddr = '0;
    logic [12:0] dir_wdata = '0;
    logic        pt_we = 1'b0;
    logic [9:0]  pt_waddr = '0;
    logic [31:0] pt_wdata = '0;
    logic [31:0] phys_addr;
    logic        phys_valid;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    // bench's own view of table contents
    logic [12:0] dir_m [32];
    logic [31:0] pt_m  [1024];

    always #2.5 clk = ~clk;

    pgx_translator u0 (.*);

    function automatic logic [31:0] walk_exp(input logic [31:0] a);
        logic [9:0] slot;
        slot = 10'(dir_m[a[26:22]] + 13'(a[21:12]));
        return pt_m[slot] + {20'd0, a[11:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive_req(input logic [31:0] a, input logic en, input logic h,
                             input logic [31:0] fr);
        req_valid = 1'b1; lin_addr = a; paging_en = en; hit = h; hit_frame = fr;
    endtask

    task automatic idle_req();
        req_valid = 1'b0; hit = 1'b0; hit_frame = '0;
    endtask

    // starts and ends just after a falling edge
    task automatic one_req(input string tag, input logic [31:0] a, input logic en,
                           input logic h, input logic [31:0] fr, input logic [31:0] exp);
        drive_req(a, en, h, fr);
        @(negedge clk);
        idle_req();
        @(negedge clk);
        chk({tag, " valid"}, {31'd0, phys_valid}, 32'd1);
        chk({tag, " addr"}, phys_addr, exp);
    endtask

    task automatic wr_dir(input logic [4:0] i, input logic [12:0] v);
        dir_we = 1'b1; dir_waddr = i; dir_wdata = v;
        @(negedge clk);
        dir_we = 1'b0;
        dir_m[i] = v;
    endtask

    task automatic wr_pt(input logic [9:0] i, input logic [31:0] v);
        pt_we = 1'b1; pt_waddr = i; pt_wdata = v;
        @(negedge clk);
        pt_we = 1'b0;
        pt_m[i] = v;
    endtask

    task automatic t_reset();
        chk("R8 reset valid", {31'd0, phys_valid}, 32'd0);
        chk("R8 reset addr", phys_addr, 32'd0);
        one_req("R8 walk on cleared tables", 32'h1234_5ABC, 1'b1, 1'b0, 32'h0, 32'h0000_0ABC);
    endtask

    task automatic t_bypass();
        one_req("R4 pass-through", 32'hDEAD_BEEF, 1'b0, 1'b0, 32'h0, 32'hDEAD_BEEF);
        one_req("R4 pass-through low", 32'h0000_0001, 1'b0, 1'b0, 32'h0, 32'h0000_0001);
    endtask

    task automatic t_walk();
        wr_dir(5'd1, 13'h0010);
        wr_pt(10'h015, 32'h8000_0000);
        wr_dir(5'd2, 13'h1FFF);
        wr_pt(10'h004, 32'h0000_4000);
        wr_dir(5'd3, 13'h0020);
        wr_pt(10'h020, 32'hFFFF_F800);
        one_req("R3 basic walk", 32'h0040_5123, 1'b1, 1'b0, 32'h0, walk_exp(32'h0040_5123));
        chk("R3 basic walk value", walk_exp(32'h0040_5123), 32'h8000_0123);
        one_req("R1 upper DIR bits ignored", 32'h0840_5123, 1'b1, 1'b0, 32'h0, 32'h8000_0123);
        one_req("R2 slot sum wraps", 32'h0080_5010, 1'b1, 1'b0, 32'h0, 32'h0000_4010);
        one_req("R3 offset carry dropped", 32'h00C0_0FFF, 1'b1, 1'b0, 32'h0, 32'h0000_07FF);
    endtask

    task automatic t_hit();
        one_req("R5 hit frame", 32'h0040_5123, 1'b1, 1'b1, 32'hCAFE_0000, 32'hCAFE_0000);
        one_req("R10 hit ignored when paging off", 32'h0040_5123, 1'b0, 1'b1,
                32'h1111_0000, 32'h0040_5123);
    endtask

    task automatic t_stream();
        drive_req(32'h0040_5123, 1'b1, 1'b0, 32'h0);
        @(negedge clk);
        drive_req(32'h0000_0000, 1'b1, 1'b1, 32'h5555_AAAA);
        @(negedge clk);
        chk("R6 stream first valid", {31'd0, phys_valid}, 32'd1);
        chk("R6 stream first addr", phys_addr, 32'h8000_0123);
        drive_req(32'h0F0F_0F0F, 1'b0, 1'b0, 32'h0);
        @(negedge clk);
        chk("R6 stream second valid", {31'd0, phys_valid}, 32'd1);
        chk("R6 stream second addr", phys_addr, 32'h5555_AAAA);
        idle_req();
        @(negedge clk);
        chk("R6 stream third valid", {31'd0, phys_valid}, 32'd1);
        chk("R6 stream third addr", phys_addr, 32'h0F0F_0F0F);
        @(negedge clk);
        chk("R7 idle valid low", {31'd0, phys_valid}, 32'd0);
        chk("R7 idle addr held", phys_addr, 32'h0F0F_0F0F);
        @(negedge clk);
        chk("R7 idle addr still held", phys_addr, 32'h0F0F_0F0F);
    endtask

    task automatic t_collide();
        logic [31:0] old_exp;
        old_exp = walk_exp(32'h00C0_0FFF);
        drive_req(32'h00C0_0FFF, 1'b1, 1'b0, 32'h0);
        dir_we = 1'b1; dir_waddr = 5'd3; dir_wdata = 13'h0015;
        @(negedge clk);
        dir_we = 1'b0; dir_m[3] = 13'h0015;
        idle_req();
        @(negedge clk);
        chk("R9 same-edge request uses old entry", phys_addr, old_exp);
        one_req("R9 later request uses new entry", 32'h00C0_0FFF, 1'b1, 1'b0, 32'h0, 32'h8000_0FFF);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) dir_m[i] = '0;
        for (int i = 0; i < 1024; i++) pt_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bypass();
        t_walk();
        t_hit();
        t_stream();
        t_collide();
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL R6 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule